// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Format Detection

This block is the per-channel digital serial interface of a voice channel. In each 8 kHz frame it shifts one 8-bit PCM word out on the transmit side and collects one on the receive side. The transmit side drives serial data, an output enable that stands for the tri-state control, and an active-low slot indicator that can enable an external bus driver. The receive side samples serial data, presents the finished word on a holding register, and raises a one-cycle decode strobe when the next frame begins.

The block chooses between two timing conventions without any configuration. It counts the falling bit-clock edges seen while a frame sync is high. A pulse that spans one falling edge selects short-frame timing, and a pulse that spans three or more selects long-frame timing. A width of two leaves the stored choice as it was. Each new choice applies from the next frame onward. Normally the transmit frame sync is measured and its result governs both directions. When `rx_half_mode` is high, the transmit side stays released and the receive frame sync is measured instead.

Every pin is sampled in a single fast clock domain, and the bit-clock edges are found by comparing successive samples. A pin change therefore reaches the outputs two system-clock cycles later. The bit clocks must be slow enough that each high phase and each low phase lasts several system cycles.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset `tx_oe` is 0, `tx_slot_n` is 1, `tx_dout` is 0, `rx_decode` is 0, `rx_word` is 0, and long-frame timing is assumed.
- R2: A frame-sync pulse that spans exactly one falling bit-clock edge selects short timing. A pulse that spans three or more selects long timing. A pulse that spans two leaves the format unchanged. The new format takes effect when the pulse falls.
- R3: In long timing, the output is enabled with the most significant bit as soon as the frame sync and the bit clock are both high. The next seven rising bit-clock edges present the remaining bits, most significant first.
- R4: In long timing, the output is released at the later of two events: the eighth falling bit-clock edge after the start, or the fall of the frame sync. A frame sync that stays high beyond eight bit periods therefore keeps the output enabled until it falls.
- R5: In short timing, the frame sync is captured on a falling bit-clock edge. The output is enabled with the most significant bit on the following rising edge, and it is released on the eighth falling edge after that.
- R6: `tx_slot_n` is low exactly while `tx_oe` is high.
- R7: In long timing, the receiver takes `rx_din` on the eight falling bit-clock edges after a rising receive frame sync, most significant bit first.
- R8: In short timing, the receiver skips the first falling edge after the frame-sync rise and takes the next eight, most significant bit first.
- R9: A rising receive frame sync produces a one-cycle `rx_decode` pulse, with `rx_word` updated to the word completed in the previous frame. No pulse is produced if no complete word has been received since the previous rise, and `rx_word` changes only together with the pulse.
- R10: While `rx_half_mode` is 1, `tx_oe` stays 0 and `tx_slot_n` stays 1, and the format is measured from the receive frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples every pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_half_mode | input | 1 | 1: receive-only operation, transmit released, format taken from the receive sync |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_word | input | WORD_W | Word to send, captured when the output is enabled |
| tx_dout | output | 1 | Transmit serial data, 0 while released |
| tx_oe | output | 1 | Output enable for the serial data driver |
| tx_slot_n | output | 1 | Active-low time-slot indicator |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_din | input | 1 | Receive serial data |
| rx_word | output | WORD_W | Word completed in the previous frame |
| rx_decode | output | 1 | One-cycle decode strobe |

## Verification
The bench concentrates on the frames where the format switches. In those frames the stored format and the shape of the pulse disagree. A design that decided per pulse instead of from the stored result would enable in the first bit period when it should enable in the second, and the receiver would pick up a word shifted by one bit. The bench also applies a width-two pulse, which must leave the format alone, and a transmit sync held for eleven periods, which a design releasing strictly on the eighth falling edge would cut short. Receive-only frames confirm that the transmit pins stay quiet and that the receive sync takes over the measurement. The first frame after reset confirms that no decode strobe is issued for a word that was never received.

// File: rtl/pcm_sp_pkg.sv
package pcm_sp_pkg;

    typedef enum logic {
        FMT_LONG  = 1'b0,
        FMT_SHORT = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic tx_bclk;
        logic tx_fs;
        logic rx_bclk;
        logic rx_fs;
    } pin_sample_t;

endpackage

// File: rtl/pcm_fmt_detect.sv
module pcm_fmt_detect
    import pcm_sp_pkg::*;
#(
    parameter int LONG_MIN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_fall,
    input  logic       fs_cur,
    input  logic       fs_prev,
    output frame_fmt_e fmt_o
);
    localparam int CW = $clog2(LONG_MIN + 1);
    localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        frame_fmt_e    fmt;
    } det_state_t;

    det_state_t q, d;

    always_comb begin
        d = q;
        if (fs_cur && bclk_fall && q.cnt != SAT) begin
            d.cnt = q.cnt + 1'b1;
        end
        if (fs_prev && !fs_cur) begin
            if (q.cnt == CW'(1)) begin
                d.fmt = FMT_SHORT;
            end else if (q.cnt == SAT) begin
                d.fmt = FMT_LONG;
            end
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fmt_o = q.fmt;

    // R2: the format only moves when a frame sync has just fallen
    a_r2_fmt_moves_on_fs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.fmt) |-> $past(fs_prev && !fs_cur));

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_sp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  frame_fmt_e        fmt_i,
    input  logic              bclk_cur,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fs_cur,
    input  logic [WORD_W-1:0] word_i,
    output logic              dout_o,
    output logic              oe_o
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] FULL = CW'(WORD_W);

    typedef struct packed {
        logic              active;
        logic              armed;
        logic              used;
        logic              dout;
        logic [WORD_W-1:0] sh;
        logic [CW-1:0]     rises;
        logic [CW-1:0]     falls;
    } tx_state_t;

    tx_state_t q, d;

    always_comb begin
        d = q;
        if (!fs_cur && !q.active && !q.armed) begin
            d.used = 1'b0;
        end
        if (!en_i) begin
            d = '0;
        end else if (!q.active) begin
            if (fmt_i == FMT_LONG) begin
                d.armed = 1'b0;
                if (fs_cur && bclk_cur && !q.used) begin
                    d.active = 1'b1;
                    d.used   = 1'b1;
                    d.dout   = word_i[WORD_W-1];
                    d.sh     = {word_i[WORD_W-2:0], 1'b0};
                    d.rises  = CW'(1);
                    d.falls  = '0;
                end
            end else begin
                if (q.armed && bclk_rise) begin
                    d.active = 1'b1;
                    d.armed  = 1'b0;
                    d.dout   = word_i[WORD_W-1];
                    d.sh     = {word_i[WORD_W-2:0], 1'b0};
                    d.rises  = CW'(1);
                    d.falls  = '0;
                end else if (!q.armed && !q.used && fs_cur && bclk_fall) begin
                    d.armed = 1'b1;
                    d.used  = 1'b1;
                end
            end
        end else begin
            if (bclk_rise && q.rises != FULL) begin
                d.dout  = q.sh[WORD_W-1];
                d.sh    = {q.sh[WORD_W-2:0], 1'b0};
                d.rises = q.rises + 1'b1;
            end
            if (bclk_fall && q.falls != FULL) begin
                d.falls = q.falls + 1'b1;
            end
            if (q.falls == FULL && (fmt_i == FMT_SHORT || !fs_cur)) begin
                d.active = 1'b0;
                d.dout   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout_o = q.dout;
    assign oe_o   = q.active;

    // R10: a disabled lane is released on the next cycle
    a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !q.active);

    // R4: R5: a release always follows eight falling edges
    a_r4_release_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.active) && $past(en_i)) |-> ($past(q.falls) == FULL));

    // R4: long timing keeps driving while the frame sync is high
    a_r4_hold_while_fs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && en_i && fmt_i == FMT_LONG && fs_cur) |=> q.active);

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_sp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_fmt_e        fmt_i,
    input  logic              fs_rise,
    input  logic              bclk_fall,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o,
    output logic              strobe_o
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic              collect;
        logic              skip;
        logic [CW-1:0]     idx;
        logic [WORD_W-1:0] sh;
        logic              got;
        logic [WORD_W-1:0] word;
        logic              strobe;
    } rx_state_t;

    rx_state_t q, d;

    always_comb begin
        d = q;
        d.strobe = 1'b0;
        if (fs_rise) begin
            d.strobe  = q.got;
            if (q.got) begin
                d.word = q.sh;
            end
            d.got     = 1'b0;
            d.collect = 1'b1;
            d.skip    = (fmt_i == FMT_SHORT);
            d.idx     = '0;
        end else if (q.collect && bclk_fall) begin
            if (q.skip) begin
                d.skip = 1'b0;
            end else begin
                d.sh = {q.sh[WORD_W-2:0], din_i};
                if (q.idx == LAST) begin
                    d.collect = 1'b0;
                    d.got     = 1'b1;
                    d.idx     = '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o   = q.word;
    assign strobe_o = q.strobe;

    // R9: the strobe lasts a single cycle
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |=> !q.strobe);

    // R9: the strobe answers a frame-sync rise
    a_r9_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |-> $past(fs_rise));

    // R9: the presented word changes only with the strobe
    a_r9_word_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.word) |-> q.strobe);

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_sp_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int LONG_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_half_mode,
    input  logic              tx_bclk,
    input  logic              tx_fs,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_dout,
    output logic              tx_oe,
    output logic              tx_slot_n,
    input  logic              rx_bclk,
    input  logic              rx_fs,
    input  logic              rx_din,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_decode
);
    typedef struct packed {
        pin_sample_t cur;
        pin_sample_t prev;
        logic        din;
    } smp_state_t;

    smp_state_t st_q, st_d;

    always_comb begin
        st_d             = st_q;
        st_d.prev        = st_q.cur;
        st_d.cur.tx_bclk = tx_bclk;
        st_d.cur.tx_fs   = tx_fs;
        st_d.cur.rx_bclk = rx_bclk;
        st_d.cur.rx_fs   = rx_fs;
        st_d.din         = rx_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic tx_rise_w, tx_fall_w, rx_fall_w, rx_fs_rise_w;
    logic det_fall_w, det_fs_cur_w, det_fs_prev_w, oe_w;
    frame_fmt_e fmt_w;

    assign tx_rise_w    = st_q.cur.tx_bclk & ~st_q.prev.tx_bclk;
    assign tx_fall_w    = ~st_q.cur.tx_bclk & st_q.prev.tx_bclk;
    assign rx_fall_w    = ~st_q.cur.rx_bclk & st_q.prev.rx_bclk;
    assign rx_fs_rise_w = st_q.cur.rx_fs & ~st_q.prev.rx_fs;

    assign det_fall_w    = rx_half_mode ? rx_fall_w         : tx_fall_w;
    assign det_fs_cur_w  = rx_half_mode ? st_q.cur.rx_fs    : st_q.cur.tx_fs;
    assign det_fs_prev_w = rx_half_mode ? st_q.prev.rx_fs   : st_q.prev.tx_fs;

    pcm_fmt_detect #(.LONG_MIN(LONG_MIN)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (det_fall_w),
        .fs_cur    (det_fs_cur_w),
        .fs_prev   (det_fs_prev_w),
        .fmt_o     (fmt_w)
    );

    pcm_tx_lane #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (~rx_half_mode),
        .fmt_i     (fmt_w),
        .bclk_cur  (st_q.cur.tx_bclk),
        .bclk_rise (tx_rise_w),
        .bclk_fall (tx_fall_w),
        .fs_cur    (st_q.cur.tx_fs),
        .word_i    (tx_word),
        .dout_o    (tx_dout),
        .oe_o      (oe_w)
    );

    pcm_rx_lane #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt_w),
        .fs_rise   (rx_fs_rise_w),
        .bclk_fall (rx_fall_w),
        .din_i     (st_q.din),
        .word_o    (rx_word),
        .strobe_o  (rx_decode)
    );

    assign tx_oe     = oe_w;
    assign tx_slot_n = ~oe_w;

endmodule

// File: tb/tb_pcm_serial_port.sv
module tb_pcm_serial_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, half, bclk, tfs, rfs, din;
    logic [7:0] txw;
    logic       tx_dout, tx_oe, tx_slot_n, rx_decode;
    logic [7:0] rx_word;

    pcm_serial_port dut (
        .clk(clk), .rst_n(rst_n), .rx_half_mode(half),
        .tx_bclk(bclk), .tx_fs(tfs), .tx_word(txw),
        .tx_dout(tx_dout), .tx_oe(tx_oe), .tx_slot_n(tx_slot_n),
        .rx_bclk(bclk), .rx_fs(rfs), .rx_din(din),
        .rx_word(rx_word), .rx_decode(rx_decode)
    );

    int checks = 0, errors = 0;
    bit done = 0, model_short = 0, have_rx = 0;
    logic [7:0] prev_rx;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic frame(input bit shortf, input int w, input logic [7:0] tw,
                         input logic [7:0] rw, input bit hm);
        int np;
        logic din_p [0:15];
        logic [7:0] exp_rx;
        int st;
        np = ((w > 9) ? w : 9) + 2;
        for (int p = 0; p < 16; p++) din_p[p] = 1'b0;
        for (int i = 0; i < 8; i++) din_p[(shortf ? 1 : 0) + i] = rw[7-i];
        st = model_short ? 1 : 0;
        for (int i = 0; i < 8; i++) exp_rx[7-i] = din_p[st + i];
        if (have_rx) rxq.push_back(prev_rx);
        if (!hm) txq.push_back(tw);
        txw = tw;
        for (int p = 0; p < np; p++) begin
            bclk = 1'b1; tfs = !hm && (p < w); rfs = (p < w); din = din_p[p];
            repeat (4) @(negedge clk);
            if (p == 0) chk(tx_oe == (!hm && !model_short), "R2 R3 R5 enable in first period", tx_oe, !hm && !model_short);
            if (p == 1) chk(tx_oe == !hm, "R3 R5 enabled by second period", tx_oe, !hm);
            if (!hm && !model_short && w <= 7 && p == 7) chk(tx_oe == 1'b1, "R4 driven in eighth bit", tx_oe, 1);
            if (!hm && !model_short && w > 8 && p == w) chk(tx_oe == 1'b0, "R4 release on fs fall", tx_oe, 0);
            if (!hm && model_short && p == 8) chk(tx_oe == 1'b1, "R5 driven in eighth bit", tx_oe, 1);
            if (hm && (p == 0 || p == 4)) chk(!tx_oe && tx_slot_n, "R10 transmit quiet", {tx_oe, tx_slot_n}, 2'b01);
            repeat (4) @(negedge clk);
            bclk = 1'b0;
            repeat (4) @(negedge clk);
            if (!hm && !model_short && w <= 7 && p == 7) chk(tx_oe == 1'b0, "R4 release on eighth fall", tx_oe, 0);
            if (!hm && !model_short && w > 8 && p == w - 1) chk(tx_oe == 1'b1, "R4 held while fs high", tx_oe, 1);
            if (!hm && model_short && p == 8) chk(tx_oe == 1'b0, "R5 release on eighth fall", tx_oe, 0);
            repeat (4) @(negedge clk);
        end
        tfs = 1'b0; rfs = 1'b0; din = 1'b0;
        prev_rx = exp_rx;
        have_rx = 1'b1;
        if (w == 1) model_short = 1'b1;
        else if (w >= 3) model_short = 1'b0;
    endtask

    // transmit monitor
    initial begin
        forever begin
            logic [7:0] got;
            logic [7:0] exp;
            @(posedge tx_oe);
            repeat (2) @(negedge clk);
            got[7] = tx_dout;
            chk(tx_slot_n == 1'b0, "R6 slot low with enable", tx_slot_n, 0);
            for (int i = 6; i >= 0; i--) begin
                @(posedge bclk);
                repeat (4) @(negedge clk);
                got[i] = tx_dout;
                chk(tx_oe && !tx_slot_n, "R6 slot tracks enable", {tx_oe, tx_slot_n}, 2'b10);
            end
            if (txq.size() == 0) begin
                chk(1'b0, "R3 unexpected transmit word", got, 0);
            end else begin
                exp = txq.pop_front();
                chk(got == exp, "R3 R5 transmit word MSB first", got, exp);
            end
        end
    end

    // receive monitor
    initial begin
        forever begin
            logic [7:0] exp;
            @(posedge rx_decode);
            @(negedge clk);
            if (rxq.size() == 0) begin
                chk(1'b0, "R9 unexpected decode strobe", rx_word, 0);
            end else begin
                exp = rxq.pop_front();
                chk(rx_word == exp, "R7 R8 R9 received word", rx_word, exp);
            end
            @(negedge clk);
            chk(rx_decode == 1'b0, "R9 strobe one cycle", rx_decode, 0);
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; half = 1'b0; bclk = 1'b0; tfs = 1'b0; rfs = 1'b0; din = 1'b0; txw = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!tx_oe && tx_slot_n, "R1 transmit released after reset", {tx_oe, tx_slot_n}, 2'b01);
        chk(tx_dout == 1'b0, "R1 data low after reset", tx_dout, 0);
        chk(rx_decode == 1'b0, "R1 no strobe after reset", rx_decode, 0);
        chk(rx_word == 8'h00, "R1 word cleared after reset", rx_word, 0);

        frame(0, 3,  8'hA5, 8'h3C, 0);
        frame(0, 4,  8'h5A, 8'hC3, 0);
        frame(1, 1,  8'h81, 8'h7E, 0);
        frame(1, 1,  8'h96, 8'h01, 0);
        frame(0, 2,  8'h0F, 8'hF0, 0);
        frame(0, 3,  8'hC6, 8'h6C, 0);
        frame(0, 11, 8'hE7, 8'h99, 0);
        half = 1'b1;
        frame(1, 1,  8'h33, 8'hD2, 1);
        frame(1, 1,  8'h44, 8'h2B, 1);
        half = 1'b0;
        frame(0, 3,  8'h12, 8'h00, 0);
        repeat (40) @(negedge clk);
        chk(txq.size() == 0, "R3 every transmit word seen", txq.size(), 0);
        chk(rxq.size() == 0, "R9 every decode seen", rxq.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule